// File: doc/BRIEF.md
# Period Energy Accumulator with Atomic Latch

This block sums per-window active-power results for one metering channel into a live period accumulator. A strobe arrives roughly every 200 ms with one signed fixed-point power value. When the host asks for a latch, the live totals move to a snapshot in a single clock edge and the live side starts empty. The snapshot carries the following:
- the sum of non-negative window values;
- the sum of the magnitudes of negative window values;
- the number of windows;
- the largest window value;
- the milliseconds elapsed since the previous latch;
- a flag that says whether the period held any window.

The reader forms the average power as sum divided by count. The elapsed time lets it scale that average to energy.

A mode parameter picks one of two variants. The unidirectional variant keeps only the consumption side: negative windows are counted but add nothing to either sum. The bidirectional variant also builds the export-side magnitude sum. All arithmetic is integer.

Top module: `period_energy_acc`

## Requirements
- R1: After reset, every snapshot output reads zero, including `snap_valid`, `snap_peak` and `snap_elapsed_ms`.
- R2: A cycle with `latch_req` high copies the live period totals to the snapshot outputs, which show them from the next cycle on. In that same edge the live accumulator is cleared. Without a latch, the snapshot outputs hold their values.
- R3: After a latch, `snap_valid` is 1 when the latched period contained at least one accepted window, and 0 when it contained none.
- R4: `snap_win_cnt` is the number of windows accepted in the latched period. The live count saturates at 2^CNT_W-1. A window that arrives while the count is saturated is discarded entirely: it changes no sum and does not affect the peak.
- R5: In both modes, every accepted window with a value of zero or above adds its value to the positive sum `snap_pos_sum`.
- R6: With MODE = MODE_UNI (encoding 0), an accepted negative window adds nothing to either sum, but it is still counted and still competes for the peak. `snap_neg_sum` is always 0 in this mode.
- R7: With MODE = MODE_BI (encoding 1), an accepted negative window adds its magnitude to `snap_neg_sum`. This includes the most negative code, whose magnitude is 2^(PWR_W-1).
- R8: `snap_peak` is the largest signed window value accepted in the latched period. A period with no windows latches the most negative code, with the sign bit set and all other bits zero.
- R9: A window strobe in the same cycle as a latch belongs to the new period, not to the one being latched.
- R10: A latch captures the number of whole milliseconds since the previous latch, or since reset for the first latch. The value is floor(k / CLK_PER_MS) for k non-latch clock edges, and it saturates at 2^MS_W-1. Until the first latch, `snap_elapsed_ms` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_stb | input | 1 | One-cycle strobe: a window result is present |
| win_pwr | input | PWR_W | Signed two's-complement window power |
| latch_req | input | 1 | One-cycle latch command |
| snap_pos_sum | output | SUM_W | Latched sum of non-negative window values |
| snap_neg_sum | output | SUM_W | Latched sum of negative-window magnitudes (zero in unidirectional mode) |
| snap_win_cnt | output | CNT_W | Latched number of accepted windows |
| snap_peak | output | PWR_W | Latched largest signed window value |
| snap_elapsed_ms | output | MS_W | Latched milliseconds between latches |
| snap_valid | output | 1 | Latched period contained at least one window |

## Verification
The bench targets several corner cases, each paired here with the fault it would expose:
- **Window coinciding with a latch.** A design that misplaced it would report a count of one in the closing period and zero in the next.
- **Latch of an empty period.** This must clear `snap_valid` and return the most negative peak. A peak that was not re-seeded would carry the previous period's maximum forward.
- **Window-count saturation.** The bench keeps feeding larger windows after the count saturates. A design that kept adding would show a peak and sums that disagree with the count, and one that wrapped would show a small count.
- **Exact elapsed time.** Latches are spaced by known cycle gaps that include back-to-back latches. The most negative input code is also driven in both modes, where a wrong magnitude or a leaked negative value shows up directly in the sums.

// File: rtl/pea_pkg.sv
// Package: shared types for the period energy accumulator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pea_pkg;

    // Selects whether export-side (negative) power is accumulated.
    typedef enum logic {
        MODE_UNI = 1'b0,
        MODE_BI  = 1'b1
    } pea_mode_e;

endpackage

// File: rtl/pea_ms_timer.sv
// Module: pea_ms_timer
// Counts whole milliseconds since the last clear. A prescaler divides the
// clock by CLK_PER_MS; the millisecond count saturates at its maximum.
// Assumes clr is a one-cycle pulse and that a clear restarts the prescaler.
module pea_ms_timer #(
    parameter int CLK_PER_MS = 100000,
    parameter int MS_W       = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [MS_W-1:0] ms_count
);

    localparam int              PS_W    = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_MS - 1);
    localparam logic [MS_W-1:0] MS_MAX  = '1;

    logic [PS_W-1:0] prescale_q;

    // Prescaler and saturating millisecond counter, both restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
            ms_count   <= '0;
        end else if (clr) begin
            prescale_q <= '0;
            ms_count   <= '0;
        end else if (prescale_q == PS_LAST) begin
            prescale_q <= '0;
            if (ms_count != MS_MAX) begin
                ms_count <= ms_count + 1'b1;
            end
        end else begin
            prescale_q <= prescale_q + 1'b1;
        end
    end

    // R10: a clear always restarts the elapsed count from zero.
    a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ms_count == '0));

    // R10: the count never wraps from its maximum back to a small value.
    a_r10_ms_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ms_count == MS_MAX) |=> (ms_count == MS_MAX));

endmodule

// File: rtl/pea_live_acc.sv
// Module: pea_live_acc
// Live period accumulator for one channel. It holds the positive sum, the
// negative-magnitude sum (bidirectional mode only), the window count and the
// peak. A clear empties the period, and a window in the same cycle as a clear
// is added to the fresh period. Once the count is saturated, new windows are
// discarded whole.
// Assumes SUM_W >= PWR_W + CNT_W, so the sums cannot overflow while the count
// is bounded.
module pea_live_acc #(
    parameter int                  PWR_W = 24,
    parameter int                  SUM_W = 40,
    parameter int                  CNT_W = 16,
    parameter pea_pkg::pea_mode_e  MODE  = pea_pkg::MODE_BI
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    win_stb,
    input  logic signed [PWR_W-1:0] win_pwr,
    output logic [SUM_W-1:0]        pos_sum,
    output logic [SUM_W-1:0]        neg_sum,
    output logic [CNT_W-1:0]        win_cnt,
    output logic signed [PWR_W-1:0] peak
);

    localparam logic [CNT_W-1:0]        CNT_MAX    = '1;
    localparam logic signed [PWR_W-1:0] PEAK_FLOOR = {1'b1, {(PWR_W-1){1'b0}}};

    logic                    take;
    logic                    is_neg;
    logic [SUM_W-1:0]        base_pos;
    logic [CNT_W-1:0]        base_cnt;
    logic signed [PWR_W-1:0] base_peak;
    logic [SUM_W-1:0]        pos_d;
    logic [CNT_W-1:0]        cnt_d;
    logic signed [PWR_W-1:0] peak_d;

    // Next-state values: start from an empty period on clear, then add the window.
    always_comb begin
        take      = win_stb && (clr || (win_cnt != CNT_MAX));
        is_neg    = win_pwr[PWR_W-1];
        base_pos  = clr ? '0 : pos_sum;
        base_cnt  = clr ? '0 : win_cnt;
        base_peak = clr ? PEAK_FLOOR : peak;
        pos_d     = base_pos + ((take && !is_neg) ? SUM_W'($unsigned(win_pwr)) : '0);
        cnt_d     = base_cnt + CNT_W'(take);
        peak_d    = (take && (win_pwr > base_peak)) ? win_pwr : base_peak;
    end

    // Registers for the positive sum, count and peak.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_sum <= '0;
            win_cnt <= '0;
            peak    <= PEAK_FLOOR;
        end else begin
            pos_sum <= pos_d;
            win_cnt <= cnt_d;
            peak    <= peak_d;
        end
    end

    generate
        if (MODE == pea_pkg::MODE_BI) begin : g_bidir
            logic [PWR_W-1:0] mag;
            logic [SUM_W-1:0] base_neg;
            logic [SUM_W-1:0] neg_d;

            // Magnitude of a negative window, added to the export sum.
            always_comb begin
                mag      = $unsigned(-win_pwr);
                base_neg = clr ? '0 : neg_sum;
                neg_d    = base_neg + ((take && is_neg) ? SUM_W'(mag) : '0);
            end

            // Export-side register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    neg_sum <= '0;
                end else begin
                    neg_sum <= neg_d;
                end
            end

            // R7: a negative window never lowers the export sum.
            a_r7_neg_grows: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && win_stb && is_neg && win_cnt != CNT_MAX) |=> (neg_sum > $past(neg_sum)));
        end else begin : g_unidir
            // No export side exists in this variant.
            assign neg_sum = '0;

            // R6: a negative window leaves the positive sum unchanged.
            a_r6_uni_drops_neg: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && win_stb && is_neg) |=> (pos_sum == $past(pos_sum)));
        end
    endgenerate

    // R4: the count does not wrap once saturated.
    a_r4_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && win_cnt == CNT_MAX) |=> (win_cnt == CNT_MAX));

    // R9: a window arriving with the clear is the first of the new period.
    a_r9_same_cycle_window: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && win_stb) |=> (win_cnt == 1));

    // R8: an empty fresh period starts from the most negative peak.
    a_r8_peak_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !win_stb) |=> (peak == PEAK_FLOOR && win_cnt == '0));

endmodule

// File: rtl/pea_snapshot.sv
// Module: pea_snapshot
// Holds the values captured at the last latch. It loads all fields in the same
// edge in which the live side clears, and holds them otherwise.
// Assumes latch is a one-cycle pulse. Before the first latch, every field is zero.
module pea_snapshot #(
    parameter int PWR_W = 24,
    parameter int SUM_W = 40,
    parameter int CNT_W = 16,
    parameter int MS_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    latch,
    input  logic [SUM_W-1:0]        live_pos,
    input  logic [SUM_W-1:0]        live_neg,
    input  logic [CNT_W-1:0]        live_cnt,
    input  logic signed [PWR_W-1:0] live_peak,
    input  logic [MS_W-1:0]         live_ms,
    output logic [SUM_W-1:0]        snap_pos,
    output logic [SUM_W-1:0]        snap_neg,
    output logic [CNT_W-1:0]        snap_cnt,
    output logic signed [PWR_W-1:0] snap_peak,
    output logic [MS_W-1:0]         snap_ms,
    output logic                    snap_valid
);

    // Capture every live field on a latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_pos   <= '0;
            snap_neg   <= '0;
            snap_cnt   <= '0;
            snap_peak  <= '0;
            snap_ms    <= '0;
            snap_valid <= 1'b0;
        end else if (latch) begin
            snap_pos   <= live_pos;
            snap_neg   <= live_neg;
            snap_cnt   <= live_cnt;
            snap_peak  <= live_peak;
            snap_ms    <= live_ms;
            snap_valid <= (live_cnt != '0);
        end
    end

    // R2: the latched count is the live count of the cycle before.
    a_r2_copy_count: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (snap_cnt == $past(live_cnt)));

    // R3: the valid flag agrees with the latched window count.
    a_r3_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (snap_valid == (snap_cnt != '0)));

endmodule

// File: rtl/period_energy_acc.sv
// Module: period_energy_acc (top)
// Period energy accumulator: live accumulation of per-window power, a
// millisecond timer between latches, and an atomic snapshot on latch_req.
// Assumes win_stb and latch_req are single-cycle pulses synchronous to clk,
// and that SUM_W >= PWR_W + CNT_W.
module period_energy_acc #(
    parameter int                 PWR_W      = 24,
    parameter int                 SUM_W      = 40,
    parameter int                 CNT_W      = 16,
    parameter int                 MS_W       = 32,
    parameter int                 CLK_PER_MS = 100000,
    parameter pea_pkg::pea_mode_e MODE       = pea_pkg::MODE_BI
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_stb,
    input  logic signed [PWR_W-1:0] win_pwr,
    input  logic                    latch_req,
    output logic [SUM_W-1:0]        snap_pos_sum,
    output logic [SUM_W-1:0]        snap_neg_sum,
    output logic [CNT_W-1:0]        snap_win_cnt,
    output logic signed [PWR_W-1:0] snap_peak,
    output logic [MS_W-1:0]         snap_elapsed_ms,
    output logic                    snap_valid
);

    logic [SUM_W-1:0]        live_pos;
    logic [SUM_W-1:0]        live_neg;
    logic [CNT_W-1:0]        live_cnt;
    logic signed [PWR_W-1:0] live_peak;
    logic [MS_W-1:0]         live_ms;

    pea_live_acc #(
        .PWR_W (PWR_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W),
        .MODE  (MODE)
    ) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (latch_req),
        .win_stb (win_stb),
        .win_pwr (win_pwr),
        .pos_sum (live_pos),
        .neg_sum (live_neg),
        .win_cnt (live_cnt),
        .peak    (live_peak)
    );

    pea_ms_timer #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_W       (MS_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (latch_req),
        .ms_count (live_ms)
    );

    pea_snapshot #(
        .PWR_W (PWR_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W),
        .MS_W  (MS_W)
    ) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch      (latch_req),
        .live_pos   (live_pos),
        .live_neg   (live_neg),
        .live_cnt   (live_cnt),
        .live_peak  (live_peak),
        .live_ms    (live_ms),
        .snap_pos   (snap_pos_sum),
        .snap_neg   (snap_neg_sum),
        .snap_cnt   (snap_win_cnt),
        .snap_peak  (snap_peak),
        .snap_ms    (snap_elapsed_ms),
        .snap_valid (snap_valid)
    );

    // R2: without a latch, the snapshot outputs do not move.
    a_r2_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> ($stable(snap_pos_sum) && $stable(snap_neg_sum) &&
                        $stable(snap_win_cnt) && $stable(snap_peak) &&
                        $stable(snap_elapsed_ms) && $stable(snap_valid)));

    // R2: a latch empties the live count unless a window joins the new period.
    a_r2_live_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_req && !win_stb) |=> (live_cnt == '0 && live_pos == '0 && live_neg == '0));

endmodule

// File: tb/period_energy_acc_bench.sv
// Bench: scoreboard. The driver task models the live period and pushes the
// expected snapshot on each latch. The monitor pops one entry after each latch
// edge and compares both mode variants.
module period_energy_acc_bench;

    localparam int    PWR_W   = 16;
    localparam int    SUM_W   = 24;
    localparam int    CNT_W   = 4;
    localparam int    MS_W    = 16;
    localparam int    CLKMS   = 10;
    localparam longint CNT_MX = (1 << CNT_W) - 1;
    localparam longint MS_MX  = (1 << MS_W) - 1;
    localparam longint FLOOR  = -(1 << (PWR_W - 1));

    typedef struct {
        longint pos;
        longint neg;
        longint cnt;
        longint peak;
        longint ms;
        longint valid;
        string  tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    win_stb = 1'b0;
    logic signed [PWR_W-1:0] win_pwr = '0;
    logic                    latch_req = 1'b0;

    logic [SUM_W-1:0]        bi_pos, bi_neg, un_pos, un_neg;
    logic [CNT_W-1:0]        bi_cnt, un_cnt;
    logic signed [PWR_W-1:0] bi_peak, un_peak;
    logic [MS_W-1:0]         bi_ms, un_ms;
    logic                    bi_valid, un_valid;

    int checks = 0;
    int bad    = 0;
    exp_t q[$];

    longint m_pos = 0, m_neg = 0, m_cnt = 0, m_peak = FLOOR, m_edges = 0;

    always #5 clk = ~clk;

    period_energy_acc #(
        .PWR_W(PWR_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .MS_W(MS_W),
        .CLK_PER_MS(CLKMS), .MODE(pea_pkg::MODE_BI)
    ) u_period_energy_acc (
        .clk(clk), .rst_n(rst_n), .win_stb(win_stb), .win_pwr(win_pwr),
        .latch_req(latch_req), .snap_pos_sum(bi_pos), .snap_neg_sum(bi_neg),
        .snap_win_cnt(bi_cnt), .snap_peak(bi_peak), .snap_elapsed_ms(bi_ms),
        .snap_valid(bi_valid)
    );

    period_energy_acc #(
        .PWR_W(PWR_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .MS_W(MS_W),
        .CLK_PER_MS(CLKMS), .MODE(pea_pkg::MODE_UNI)
    ) u_period_energy_acc_uni (
        .clk(clk), .rst_n(rst_n), .win_stb(win_stb), .win_pwr(win_pwr),
        .latch_req(latch_req), .snap_pos_sum(un_pos), .snap_neg_sum(un_neg),
        .snap_win_cnt(un_cnt), .snap_peak(un_peak), .snap_elapsed_ms(un_ms),
        .snap_valid(un_valid)
    );

    task automatic chk(input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", what, got, exp);
        end
    endtask

    // Drive one cycle from a negedge, update the model, return at the next negedge.
    task automatic cyc(input logic stb, input int pwr, input logic lat, input string tag);
        exp_t e;
        win_stb   = stb;
        win_pwr   = PWR_W'(pwr);
        latch_req = lat;
        if (lat) begin
            e.pos   = m_pos;
            e.neg   = m_neg;
            e.cnt   = m_cnt;
            e.peak  = m_peak;
            e.ms    = ((m_edges / CLKMS) > MS_MX) ? MS_MX : (m_edges / CLKMS);
            e.valid = (m_cnt != 0) ? 1 : 0;
            e.tag   = tag;
            q.push_back(e);
            m_pos = 0; m_neg = 0; m_cnt = 0; m_peak = FLOOR; m_edges = 0;
        end else begin
            m_edges++;
        end
        // R9: a window in the latch cycle goes into the freshly cleared period.
        if (stb && m_cnt < CNT_MX) begin
            if (pwr >= 0) m_pos += pwr;
            else          m_neg += -longint'(pwr);
            m_cnt++;
            if (pwr > m_peak) m_peak = pwr;
        end
        @(negedge clk);
        win_stb   = 1'b0;
        latch_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, "");
    endtask

    // Monitor: after every latch edge, compare both variants with the expectation.
    initial begin
        exp_t e;
        logic l;
        forever begin
            @(posedge clk);
            l = latch_req;
            @(negedge clk);
            if (l) begin
                if (q.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R2 latch with no expectation got=1 exp=0");
                end else begin
                    e = q.pop_front();
                    chk({"R5 pos_sum bi ", e.tag}, longint'(bi_pos), e.pos);
                    chk({"R5 pos_sum uni ", e.tag}, longint'(un_pos), e.pos);
                    chk({"R7 neg_sum bi ", e.tag}, longint'(bi_neg), e.neg);
                    chk({"R6 neg_sum uni ", e.tag}, longint'(un_neg), 0);
                    chk({"R4 win_cnt ", e.tag}, longint'(bi_cnt), e.cnt);
                    chk({"R4 win_cnt uni ", e.tag}, longint'(un_cnt), e.cnt);
                    chk({"R8 peak ", e.tag}, longint'(bi_peak), e.peak);
                    chk({"R8 peak uni ", e.tag}, longint'(un_peak), e.peak);
                    chk({"R10 elapsed_ms ", e.tag}, longint'(bi_ms), e.ms);
                    chk({"R10 elapsed_ms uni ", e.tag}, longint'(un_ms), e.ms);
                    chk({"R3 valid ", e.tag}, longint'(bi_valid), e.valid);
                    chk({"R3 valid uni ", e.tag}, longint'(un_valid), e.valid);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired got=hang exp=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every snapshot output.
        chk("R1 pos_sum reset", longint'(bi_pos), 0);
        chk("R1 neg_sum reset", longint'(bi_neg), 0);
        chk("R1 win_cnt reset", longint'(bi_cnt), 0);
        chk("R1 peak reset", longint'(bi_peak), 0);
        chk("R1 elapsed reset", longint'(bi_ms), 0);
        chk("R1 valid reset", longint'(bi_valid), 0);
        idle(57);
        // R10: no latch yet, so elapsed still reads zero.
        chk("R10 elapsed before first latch", longint'(bi_ms), 0);
        chk("R10 elapsed before first latch uni", longint'(un_ms), 0);

        cyc(1'b0, 0, 1'b1, "empty-first");           // R3/R8 empty period

        idle(4);
        cyc(1'b1, 100, 1'b0, "");
        idle(3);
        cyc(1'b1, 250, 1'b0, "");
        cyc(1'b1, 0, 1'b0, "");
        idle(2);
        cyc(1'b1, -40, 1'b0, "");
        idle(20);
        cyc(1'b0, 0, 1'b1, "mixed");                  // R2 mixed signs

        cyc(1'b1, -5, 1'b0, "");
        idle(5);
        cyc(1'b1, -300, 1'b0, "");
        idle(11);
        cyc(1'b0, 0, 1'b1, "all-negative");

        idle(6);
        cyc(1'b1, 77, 1'b1, "before-coincident");     // R9 window rides the latch
        idle(9);
        cyc(1'b0, 0, 1'b1, "after-coincident");

        for (int i = 0; i < 15; i++) cyc(1'b1, 1000, 1'b0, "");
        for (int i = 0; i < 5; i++)  cyc(1'b1, 5000, 1'b0, "");
        cyc(1'b0, 0, 1'b1, "saturated");              // R4 saturation drop

        cyc(1'b1, -32768, 1'b0, "");
        cyc(1'b1, 32767, 1'b0, "");
        idle(30);
        cyc(1'b0, 0, 1'b1, "extremes");               // R7 most negative code

        cyc(1'b0, 0, 1'b1, "back-to-back");           // R10 zero gap, R3 empty

        idle(123);
        cyc(1'b1, 12, 1'b1, "long-gap");
        idle(4);
        cyc(1'b0, 0, 1'b1, "tail");
        idle(4);

        if (q.size() != 0) begin
            checks++; bad++;
            $display("FAIL R2 unconsumed expectations got=%0d exp=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule